// File: doc/BRIEF.md
# Multi-Mode DSP Address Generator

This block forms the word address of a load or store and, for the two pointer-walking modes, the rewritten value of the index/modifier register. It offers four addressing modes. An absolute mode spreads an 18-bit constant across the address with a zero gap. A base-plus-displacement mode adds a signed 10-bit displacement to a base register. A bit-reversed walk steps an index through reversed-carry addition, as used for FFT buffers. A circular walk steps an index through a ring buffer whose size is kept in the upper half of the same register.

The mode and its offsets come either from explicit inputs or from a 32-bit instruction word that the block decodes itself. Instruction words that match none of the accepted encodings are reported and never cause a register write. A request is taken on `req_valid`, and all results appear together on registered outputs in the following cycle. The register file and the memory access are outside this block.

Top module: `agen_top`

## Requirements
- R1: While reset is held, and until the first request after reset, `rsp_valid`, `mod_we`, `illegal_insn` and `len_err` are 0.
- R2: A request sampled on a rising edge with `req_valid`=1 yields `rsp_valid`=1 after that edge. A cycle without a request yields `rsp_valid`=0 and `mod_we`=`illegal_insn`=`len_err`=0.
- R3: Absolute mode gives `eff_addr` = {off_long[17:14], fourteen 0 bits, off_long[13:0]} and `mod_we`=0.
- R4: Base-plus-displacement mode gives `eff_addr` = base + sign-extended off_short (modulo 2^32) and `mod_we`=0.
- R5: Bit-reverse mode gives `eff_addr` = base + zero-extended mod[15:0]. It writes `mod_next` = {mod[31:16], rev16(rev16(mod[15:0]) + rev16(mod[31:16]))}, where the inner sum is taken modulo 2^16, and sets `mod_we`=1.
- R6: Circular mode gives `eff_addr` = base + the old index mod[15:0]. When the stepped index s = index + sext(off_short) satisfies 0 <= s < length (length = mod[31:16]), it writes {length, s}.
- R7: Circular mode with s >= length writes {length, s - length}. This includes s == length, which gives 0.
- R8: Circular mode with s < 0 writes {length, s + length}. The block relies on |off_short| < length and index < length.
- R9: Circular mode with length 0 sets `len_err`=1 and `mod_we`=0, and `mod_next` equals the incoming modifier value.
- R10: With `use_insn`=1, the fields are taken from the instruction word: off_short = {insn[31:28], insn[21:16]}; absolute off_long = {insn[15:12], insn[25:22], insn[31:28], insn[21:16]}. The accepted encodings are opcode insn[7:0]=0xE5 with insn[27:26]=01 (absolute), 0x49 with insn[27:22]=0x21 (displacement), 0x69 with insn[27:22]=0x01 (bit-reverse), and 0x69 with insn[27:22]=0x11 (circular).
- R11: Any other instruction word, with `use_insn`=1, sets `illegal_insn`=1 and forces `mod_we`=0 and `len_err`=0.
- R12: With `use_insn`=0, `mode_sel` selects 0 absolute, 1 displacement, 2 bit-reverse, 3 circular, and `illegal_insn` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| use_insn | input | 1 | 1: decode the instruction word; 0: use the explicit fields |
| insn | input | 32 | Instruction word |
| mode_sel | input | 2 | Explicit mode |
| off_long | input | 18 | Explicit absolute constant |
| off_short | input | 10 | Explicit signed displacement/step |
| base_reg | input | 32 | Base register value |
| mod_reg | input | 32 | Index/modifier register value |
| rsp_valid | output | 1 | Result valid |
| eff_addr | output | 32 | Effective address |
| mod_next | output | 32 | Rewritten modifier register |
| mod_we | output | 1 | Write enable for `mod_next` |
| illegal_insn | output | 1 | Unrecognised instruction word |
| len_err | output | 1 | Circular length of zero |

## Verification
The circular mode produces two results in the same cycle: the address, which must use the old index, and the rewritten index, which may wrap. Both must be correct when a wrap happens. The bench drives circular requests whose steps land exactly on the length, just past it, and below zero. It feeds each rewritten modifier back into the next request, and it checks in the same sampled cycle that the address uses the pre-step index while `mod_next` carries the wrapped one. The same pairing is judged for the bit-reverse walk across a full reversed cycle.

// File: rtl/agen_pkg.sv
`timescale 1ns/1ps
package agen_pkg;
  localparam int INSN_W      = 32;
  localparam int OFF_LONG_W  = 18;
  localparam int OFF_SHORT_W = 10;
  localparam int ABS_SPLIT   = 14;

  typedef enum logic [1:0] {
    AM_ABS  = 2'd0,
    AM_BOFS = 2'd1,
    AM_BREV = 2'd2,
    AM_CIRC = 2'd3
  } agen_mode_e;

  localparam logic [7:0] OPC_ABS  = 8'hE5;
  localparam logic [7:0] OPC_BOFS = 8'h49;
  localparam logic [7:0] OPC_PTR  = 8'h69;
  localparam logic [1:0] SUB_ABS  = 2'b01;
  localparam logic [5:0] SUB_BOFS = 6'h21;
  localparam logic [5:0] SUB_BREV = 6'h01;
  localparam logic [5:0] SUB_CIRC = 6'h11;
endpackage

// File: rtl/agen_decode.sv
`timescale 1ns/1ps
module agen_decode
  import agen_pkg::*;
(
  input  logic [INSN_W-1:0]      insn,
  output agen_mode_e             mode,
  output logic [OFF_LONG_W-1:0]  off_long,
  output logic [OFF_SHORT_W-1:0] off_short,
  output logic                   legal
);
  logic [7:0] opc;
  logic [5:0] sub;

  assign opc = insn[7:0];
  assign sub = insn[27:22];

  // displacement and long constant share the scattered low fields
  assign off_short = {insn[31:28], insn[21:16]};
  assign off_long  = {insn[15:12], insn[25:22], insn[31:28], insn[21:16]};

  always_comb begin
    mode  = AM_BOFS;
    legal = 1'b0;
    if (opc == OPC_ABS && insn[27:26] == SUB_ABS) begin
      mode  = AM_ABS;
      legal = 1'b1;
    end else if (opc == OPC_BOFS && sub == SUB_BOFS) begin
      mode  = AM_BOFS;
      legal = 1'b1;
    end else if (opc == OPC_PTR && sub == SUB_BREV) begin
      mode  = AM_BREV;
      legal = 1'b1;
    end else if (opc == OPC_PTR && sub == SUB_CIRC) begin
      mode  = AM_CIRC;
      legal = 1'b1;
    end
  end
endmodule

// File: rtl/agen_brev.sv
`timescale 1ns/1ps
module agen_brev #(
  parameter int IDX_W = 16
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] incr,
  output logic [IDX_W-1:0] nxt
);
  logic [IDX_W-1:0] r_idx;
  logic [IDX_W-1:0] r_inc;
  logic [IDX_W-1:0] r_sum;

  // reversed-carry add: mirror, add, mirror back
  for (genvar g = 0; g < IDX_W; g++) begin : g_mirror
    assign r_idx[g] = idx[IDX_W-1-g];
    assign r_inc[g] = incr[IDX_W-1-g];
    assign nxt[g]   = r_sum[IDX_W-1-g];
  end

  assign r_sum = r_idx + r_inc;
endmodule

// File: rtl/agen_circ.sv
`timescale 1ns/1ps
module agen_circ #(
  parameter int IDX_W = 16,
  parameter int OFF_W = 10
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] len,
  input  logic [OFF_W-1:0] step,
  output logic [IDX_W-1:0] nxt,
  output logic             len_zero
);
  localparam int SW = IDX_W + 2;

  logic signed [SW-1:0] s_idx;
  logic signed [SW-1:0] s_len;
  logic signed [SW-1:0] s_step;
  logic signed [SW-1:0] s_sum;
  logic signed [SW-1:0] s_wrap;

  always_comb begin
    s_idx  = $signed({2'b00, idx});
    s_len  = $signed({2'b00, len});
    s_step = $signed({{(SW-OFF_W){step[OFF_W-1]}}, step});
    s_sum  = s_idx + s_step;
    // one correction each way; valid while |step| < len and idx < len
    if (s_sum[SW-1]) begin
      s_wrap = s_sum + s_len;
    end else if (s_sum >= s_len) begin
      s_wrap = s_sum - s_len;
    end else begin
      s_wrap = s_sum;
    end
  end

  assign nxt      = s_wrap[IDX_W-1:0];
  assign len_zero = (len == '0);
endmodule

// File: rtl/agen_top.sv
`timescale 1ns/1ps
module agen_top
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   use_insn,
  input  logic [INSN_W-1:0]      insn,
  input  logic [1:0]             mode_sel,
  input  logic [OFF_LONG_W-1:0]  off_long,
  input  logic [OFF_SHORT_W-1:0] off_short,
  input  logic [ADDR_W-1:0]      base_reg,
  input  logic [2*IDX_W-1:0]     mod_reg,
  output logic                   rsp_valid,
  output logic [ADDR_W-1:0]      eff_addr,
  output logic [2*IDX_W-1:0]     mod_next,
  output logic                   mod_we,
  output logic                   illegal_insn,
  output logic                   len_err
);
  localparam int MOD_W   = 2 * IDX_W;
  localparam int ABS_GAP = ADDR_W - OFF_LONG_W;
  localparam int ABS_HI  = OFF_LONG_W - ABS_SPLIT;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_n;
  logic rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  // field source
  agen_mode_e             dec_mode;
  logic [OFF_LONG_W-1:0]  dec_off_long;
  logic [OFF_SHORT_W-1:0] dec_off_short;
  logic                   dec_legal;

  agen_decode u_decode (
    .insn      (insn),
    .mode      (dec_mode),
    .off_long  (dec_off_long),
    .off_short (dec_off_short),
    .legal     (dec_legal)
  );

  agen_mode_e             cur_mode;
  logic [OFF_LONG_W-1:0]  cur_off_long;
  logic [OFF_SHORT_W-1:0] cur_off_short;
  logic                   cur_legal;

  always_comb begin
    if (use_insn) begin
      cur_mode      = dec_mode;
      cur_off_long  = dec_off_long;
      cur_off_short = dec_off_short;
      cur_legal     = dec_legal;
    end else begin
      cur_mode      = agen_mode_e'(mode_sel);
      cur_off_long  = off_long;
      cur_off_short = off_short;
      cur_legal     = 1'b1;
    end
  end

  // pointer arithmetic units
  logic [IDX_W-1:0] idx_lo;
  logic [IDX_W-1:0] idx_hi;
  logic [IDX_W-1:0] brev_nxt;
  logic [IDX_W-1:0] circ_nxt;
  logic             circ_len_zero;

  assign idx_lo = mod_reg[IDX_W-1:0];
  assign idx_hi = mod_reg[MOD_W-1:IDX_W];

  agen_brev #(.IDX_W(IDX_W)) u_brev (
    .idx  (idx_lo),
    .incr (idx_hi),
    .nxt  (brev_nxt)
  );

  agen_circ #(.IDX_W(IDX_W), .OFF_W(OFF_SHORT_W)) u_circ (
    .idx      (idx_lo),
    .len      (idx_hi),
    .step     (cur_off_short),
    .nxt      (circ_nxt),
    .len_zero (circ_len_zero)
  );

  // next-state
  logic [ADDR_W-1:0] abs_addr;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] idx_ext;
  logic [ADDR_W-1:0] addr_d;
  logic [MOD_W-1:0]  mod_d;
  logic              we_d;
  logic              ill_d;
  logic              lerr_d;

  assign abs_addr = {cur_off_long[OFF_LONG_W-1:ABS_SPLIT], {ABS_GAP{1'b0}},
                     cur_off_long[ABS_SPLIT-1:0]};
  assign disp_ext = {{(ADDR_W-OFF_SHORT_W){cur_off_short[OFF_SHORT_W-1]}}, cur_off_short};
  assign idx_ext  = {{(ADDR_W-IDX_W){1'b0}}, idx_lo};

  always_comb begin
    mod_d  = mod_reg;
    we_d   = 1'b0;
    ill_d  = 1'b0;
    lerr_d = 1'b0;
    unique case (cur_mode)
      AM_ABS:  addr_d = abs_addr;
      AM_BOFS: addr_d = base_reg + disp_ext;
      AM_BREV: begin
        addr_d = base_reg + idx_ext;
        mod_d  = {idx_hi, brev_nxt};
        we_d   = 1'b1;
      end
      default: begin
        addr_d = base_reg + idx_ext;
        if (circ_len_zero) begin
          lerr_d = 1'b1;
        end else begin
          mod_d = {idx_hi, circ_nxt};
          we_d  = 1'b1;
        end
      end
    endcase
    if (!cur_legal) begin
      we_d   = 1'b0;
      lerr_d = 1'b0;
      ill_d  = 1'b1;
    end
  end

  // flag registers, updated every cycle
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_valid    <= 1'b0;
      mod_we       <= 1'b0;
      illegal_insn <= 1'b0;
      len_err      <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      mod_we       <= req_valid & we_d;
      illegal_insn <= req_valid & ill_d;
      len_err      <= req_valid & lerr_d;
    end
  end

  // data registers, clock-enabled by the request
  agen_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      eff_addr <= '0;
      mod_next <= '0;
      mode_q   <= AM_ABS;
    end else if (req_valid) begin
      eff_addr <= addr_d;
      mod_next <= mod_d;
      mode_q   <= cur_mode;
    end
  end
endmodule

// File: rtl/agen_chk.sv
`timescale 1ns/1ps
module agen_chk
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input logic                   clk,
  input logic                   rst_q_n,
  input logic                   req_valid,
  input agen_mode_e             cur_mode,
  input logic                   cur_legal,
  input logic [OFF_SHORT_W-1:0] cur_off_short,
  input logic [2*IDX_W-1:0]     mod_reg,
  input agen_mode_e             mode_q,
  input logic                   rsp_valid,
  input logic [ADDR_W-1:0]      eff_addr,
  input logic [2*IDX_W-1:0]     mod_next,
  input logic                   mod_we,
  input logic                   illegal_insn,
  input logic                   len_err
);
  localparam int MOD_W   = 2 * IDX_W;
  localparam int ABS_GAP = ADDR_W - OFF_LONG_W;

  logic [OFF_SHORT_W:0] step_mag;
  logic [IDX_W-1:0]     in_len;

  always_comb begin
    step_mag = cur_off_short[OFF_SHORT_W-1]
             ? (~{1'b1, cur_off_short} + 1'b1)
             : {1'b0, cur_off_short};
    in_len   = mod_reg[MOD_W-1:IDX_W];
  end

  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid |=> rsp_valid);

  a_r2_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |=> !rsp_valid);

  a_r1_flags_need_rsp: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mod_we || illegal_insn || len_err) |-> rsp_valid);

  a_r11_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    illegal_insn |-> (!mod_we && !len_err));

  a_r9_zero_len_holds: assert property (@(posedge clk) disable iff (!rst_q_n)
    len_err |-> (!mod_we && mod_next == $past(mod_reg)));

  a_r7_circ_in_range: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mod_we && mode_q == AM_CIRC) |-> (mod_next[IDX_W-1:0] < mod_next[MOD_W-1:IDX_W]));

  a_r3_abs_gap_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_valid && !illegal_insn && mode_q == AM_ABS) |-> (eff_addr[ABS_SPLIT +: ABS_GAP] == '0));

  a_r8_step_below_len: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && cur_legal && cur_mode == AM_CIRC && in_len != '0)
      |-> ({{(IDX_W-OFF_SHORT_W-1){1'b0}}, step_mag} < in_len));
endmodule

bind agen_top agen_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_agen_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .req_valid     (req_valid),
  .cur_mode      (cur_mode),
  .cur_legal     (cur_legal),
  .cur_off_short (cur_off_short),
  .mod_reg       (mod_reg),
  .mode_q        (mode_q),
  .rsp_valid     (rsp_valid),
  .eff_addr      (eff_addr),
  .mod_next      (mod_next),
  .mod_we        (mod_we),
  .illegal_insn  (illegal_insn),
  .len_err       (len_err)
);

// File: tb/tb_agen_top.sv
`timescale 1ns/1ps
module tb_agen_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        use_insn;
  logic [31:0] insn;
  logic [1:0]  mode_sel;
  logic [17:0] off_long;
  logic [9:0]  off_short;
  logic [31:0] base_reg;
  logic [31:0] mod_reg;
  logic        rsp_valid;
  logic [31:0] eff_addr;
  logic [31:0] mod_next;
  logic        mod_we;
  logic        illegal_insn;
  logic        len_err;

  agen_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .use_insn(use_insn),
    .insn(insn), .mode_sel(mode_sel), .off_long(off_long), .off_short(off_short),
    .base_reg(base_reg), .mod_reg(mod_reg), .rsp_valid(rsp_valid),
    .eff_addr(eff_addr), .mod_next(mod_next), .mod_we(mod_we),
    .illegal_insn(illegal_insn), .len_err(len_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    bit          v;
    bit          we;
    bit          ill;
    bit          le;
    bit          chk_addr;
    bit          chk_mod;
    logic [31:0] addr;
    logic [31:0] modn;
    string       tag;
  } exp_t;

  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  exp_t exp_q;

  function automatic logic [15:0] rev16(input logic [15:0] x);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = x[15-i];
    return r;
  endfunction

  function automatic exp_t model(input bit v, input bit ui, input logic [31:0] iw,
                                 input logic [1:0] ms, input logic [17:0] ol,
                                 input logic [9:0] os, input logic [31:0] b,
                                 input logic [31:0] m, input string tag);
    exp_t e;
    int md; bit legal; int so; int idx; int hi; int s;
    logic [15:0] t;
    e.v = v; e.we = 0; e.ill = 0; e.le = 0; e.chk_addr = 0; e.chk_mod = 0;
    e.addr = '0; e.modn = '0; e.tag = tag;
    if (!v) return e;
    md = ms; legal = 1;
    if (ui) begin
      os = {iw[31:28], iw[21:16]};
      if (iw[7:0] == 8'hE5 && iw[27:26] == 2'b01) begin
        md = 0; ol = {iw[15:12], iw[25:22], iw[31:28], iw[21:16]};
      end else if (iw[7:0] == 8'h49 && iw[27:22] == 6'h21) md = 1;
      else if (iw[7:0] == 8'h69 && iw[27:22] == 6'h01) md = 2;
      else if (iw[7:0] == 8'h69 && iw[27:22] == 6'h11) md = 3;
      else legal = 0;
    end
    if (!legal) begin
      e.ill = 1;
      return e;
    end
    so  = os[9] ? int'(os) - 1024 : int'(os);
    idx = int'(m[15:0]);
    hi  = int'(m[31:16]);
    e.chk_addr = 1;
    case (md)
      0: e.addr = (32'(ol >> 14) << 28) | 32'(ol & 18'h3FFF);
      1: e.addr = b + 32'(so);
      2: begin
        e.addr = b + 32'(idx);
        t = rev16(m[15:0]) + rev16(m[31:16]);
        e.modn = {m[31:16], rev16(t)};
        e.we = 1; e.chk_mod = 1;
      end
      default: begin
        e.addr = b + 32'(idx);
        e.chk_mod = 1;
        if (hi == 0) begin
          e.le = 1; e.modn = m;
        end else begin
          s = idx + so;
          if (s < 0) s = s + hi;
          else if (s >= hi) s = s - hi;
          e.modn = {m[31:16], 16'(s)};
          e.we = 1;
        end
      end
    endcase
    return e;
  endfunction

  task automatic miss(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] expv);
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
  endtask

  task automatic compare();
    bit bad = 0;
    n_vec++;
    if (rsp_valid !== exp_q.v) begin miss(exp_q.tag, "rsp_valid", 32'(rsp_valid), 32'(exp_q.v)); bad = 1; end
    if (mod_we !== exp_q.we) begin miss(exp_q.tag, "mod_we", 32'(mod_we), 32'(exp_q.we)); bad = 1; end
    if (illegal_insn !== exp_q.ill) begin miss(exp_q.tag, "illegal_insn", 32'(illegal_insn), 32'(exp_q.ill)); bad = 1; end
    if (len_err !== exp_q.le) begin miss(exp_q.tag, "len_err", 32'(len_err), 32'(exp_q.le)); bad = 1; end
    if (exp_q.v && exp_q.chk_addr && eff_addr !== exp_q.addr) begin miss(exp_q.tag, "eff_addr", eff_addr, exp_q.addr); bad = 1; end
    if (exp_q.v && exp_q.chk_mod && mod_next !== exp_q.modn) begin miss(exp_q.tag, "mod_next", mod_next, exp_q.modn); bad = 1; end
    if (bad) n_fail++;
  endtask

  // one clock: judge the previous request, then present the next one
  task automatic drive(input bit v, input bit ui, input logic [31:0] iw, input logic [1:0] ms,
                       input logic [17:0] ol, input logic [9:0] os, input logic [31:0] b,
                       input logic [31:0] m, input string tag);
    @(negedge clk);
    compare();
    req_valid = v; use_insn = ui; insn = iw; mode_sel = ms;
    off_long = ol; off_short = os; base_reg = b; mod_reg = m;
    exp_q = model(v, ui, iw, ms, ol, os, b, m, tag);
  endtask

  task automatic idle(input string tag);
    drive(0, 0, 32'h0, 2'd0, 18'h0, 10'h0, 32'h0, 32'h0, tag);
  endtask

  function automatic logic [31:0] enc_bo(input logic [7:0] opc, input logic [5:0] sub,
                                         input logic [9:0] os);
    return {os[9:6], sub, os[5:0], 4'h3, 4'h2, opc};
  endfunction

  function automatic logic [31:0] enc_abs(input logic [17:0] ol);
    return {ol[9:6], 2'b01, ol[13:10], ol[5:0], ol[17:14], 4'h4, 8'hE5};
  endfunction

  function automatic logic [31:0] enc_mode(input int md, input logic [17:0] ol,
                                           input logic [9:0] os);
    case (md)
      0:       return enc_abs(ol);
      1:       return enc_bo(8'h49, 6'h21, os);
      2:       return enc_bo(8'h69, 6'h01, os);
      default: return enc_bo(8'h69, 6'h11, os);
    endcase
  endfunction

  function automatic logic [9:0] s10(input int v);
    return 10'(v);
  endfunction

  initial begin
    #500000;
    if (!done) begin
      $display("FAIL watchdog expired");
      n_fail++;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] m;
    exp_q = model(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    rst_n = 1'b0;
    req_valid = 0; use_insn = 0; insn = 0; mode_sel = 0;
    off_long = 0; off_short = 0; base_reg = 0; mod_reg = 0;
    // R1: outputs quiet during reset
    repeat (2) begin
      @(negedge clk);
      compare();
    end
    rst_n = 1'b1;
    repeat (3) idle("R1");
    idle("R2");

    // R3 R12: absolute via mode_sel 0
    drive(1, 0, 32'hFFFF_FFFF, 2'd0, 18'h2ABCD, 10'h0, 32'hDEAD_BEEF, 32'h1234_5678, "R3");
    drive(1, 0, 32'h0, 2'd0, 18'h3FFFF, 10'h0, 32'h0, 32'h0, "R3 R12");
    // R4: displacement both signs, with carry across 32 bits
    drive(1, 0, 32'h0, 2'd1, 18'h0, s10(200), 32'h0000_1000, 32'h0, "R4");
    drive(1, 0, 32'h0, 2'd1, 18'h0, s10(-512), 32'h0000_0100, 32'h0, "R4");
    drive(1, 0, 32'h0, 2'd1, 18'h0, s10(1), 32'hFFFF_FFFF, 32'h0, "R4 R12");
    idle("R2");

    // R5: bit-reverse walk over 16 points, feeding back the rewritten register
    m = {16'h0008, 16'h0000};
    for (int k = 0; k < 18; k++) begin
      drive(1, 0, 32'h0, 2'd2, 18'h0, 10'h0, 32'h0002_0000, m, "R5");
      m = exp_q.modn;
    end

    // R6 R7 R8: circular, length 10
    drive(1, 0, 32'h0, 2'd3, 18'h0, s10(2),  32'h0000_4000, {16'd10, 16'd3}, "R6");
    drive(1, 0, 32'h0, 2'd3, 18'h0, s10(4),  32'h0000_4000, {16'd10, 16'd8}, "R7");
    drive(1, 0, 32'h0, 2'd3, 18'h0, s10(1),  32'h0000_4000, {16'd10, 16'd9}, "R7");
    drive(1, 0, 32'h0, 2'd3, 18'h0, s10(-3), 32'h0000_4000, {16'd10, 16'd1}, "R8");
    drive(1, 0, 32'h0, 2'd3, 18'h0, s10(-1), 32'h0000_4000, {16'd10, 16'd0}, "R8");
    drive(1, 0, 32'h0, 2'd3, 18'h0, s10(0),  32'h0000_4000, {16'd1, 16'd0}, "R6");
    // R9: zero length
    drive(1, 0, 32'h0, 2'd3, 18'h0, s10(5),  32'h0000_4000, {16'd0, 16'd7}, "R9");
    // back-to-back circular walk, step -7 over length 20
    m = {16'd20, 16'd4};
    for (int k = 0; k < 12; k++) begin
      drive(1, 0, 32'h0, 2'd3, 18'h0, s10(-7), 32'h8000_0000, m, "R6 R8");
      m = exp_q.modn;
    end
    idle("R2");

    // R10: decoded forms
    drive(1, 1, enc_abs(18'h1F00F), 2'd3, 18'h0, 10'h0, 32'h0, 32'h0, "R10");
    drive(1, 1, enc_bo(8'h49, 6'h21, s10(-100)), 2'd0, 18'h0, 10'h0, 32'h0000_2000, 32'h0, "R10");
    drive(1, 1, enc_bo(8'h69, 6'h01, 10'h0), 2'd0, 18'h0, 10'h0, 32'h10, {16'h4000, 16'h0002}, "R10");
    drive(1, 1, enc_bo(8'h69, 6'h11, s10(-6)), 2'd0, 18'h0, 10'h0, 32'h100, {16'd50, 16'd2}, "R10");
    // R11: rejected words
    drive(1, 1, 32'h0000_0000, 2'd2, 18'h0, 10'h0, 32'h0, {16'h1, 16'h1}, "R11");
    drive(1, 1, enc_bo(8'h69, 6'h02, 10'h0), 2'd2, 18'h0, 10'h0, 32'h0, {16'h1, 16'h1}, "R11");
    drive(1, 1, {4'h0, 2'b10, 26'h00000E5} | 32'h0000_00E5, 2'd0, 18'h0, 10'h0, 32'h0, 32'h0, "R11");
    drive(1, 1, enc_bo(8'h49, 6'h01, 10'h0), 2'd0, 18'h0, 10'h0, 32'h0, 32'h0, "R11");
    drive(1, 1, enc_bo(8'h69, 6'h11, 10'h0) ^ 32'h0000_0001, 2'd3, 18'h0, 10'h0, 32'h0, {16'd0, 16'd0}, "R11");
    idle("R2");

    // mixed traffic with idle gaps
    for (int k = 0; k < 400; k++) begin
      automatic int md = $urandom_range(0, 3);
      automatic bit ui = 1'($urandom_range(0, 1));
      automatic bit v  = ($urandom_range(0, 4) != 0);
      automatic int o  = int'($urandom_range(0, 1023)) - 512;
      automatic logic [31:0] b  = $urandom;
      automatic logic [31:0] mm = $urandom;
      automatic logic [17:0] ol = 18'($urandom);
      automatic int len;
      automatic int ix;
      if (md == 3) begin
        len = $urandom_range(1, 65535);
        ix  = $urandom_range(0, len - 1);
        if ((o < 0 ? -o : o) >= len) o = o % len;
        mm = {16'(len), 16'(ix)};
      end
      drive(v, ui, ui ? enc_mode(md, ol, s10(o)) : $urandom, 2'(md), ol, s10(o), b, mm,
            "R2 R3 R4 R5 R6 R7 R8 R10 R12");
    end
    idle("R2");
    idle("R2");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule